// File: doc/BRIEF.md
# Delay-Locked Loop Start-Up Sequencer

This block sequences the start-up of a receive delay-locked loop. Out of reset it holds the loop's delay control at a preset point, a little above the shortest delay the line can produce. It waits for the reference clock to come up, then lets the loop settle for a fixed number of cycles and ignores the phase detector during that time. It then opens a vote window. If the phase detector asks for less delay even once inside that window, the sampling clock is taken from the opposite half-period. This is a 180 degree phase inversion, chosen once for each acquisition.

After the phase decision the block drives the charge pump at its high-current setting for an acquisition interval. That interval is given in picoseconds and converted to clock cycles. The block then drops the pump back to its low-dither setting and raises a lock flag. The raw phase-detector output passes through a parameterised synchronizer before the controller uses it. If the reference clock goes away at any point, the sequence restarts from the preset step. The analog delay line and the charge pump are outside this block; it only drives their control strobes.

Top module: `dll_acq_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, `preset_o` is 1 and `invert_o`, `boost_o` and `locked_o` are 0.
- R2: `preset_o` stays 1 for as long as `ref_active_i` is 0. It falls after the first rising clock edge that samples `ref_active_i` at 1, which is called edge E0.
- R3: A phase-detector "down" (`pd_down_i` = 1) captured at edges E0 through E6 has no effect on `invert_o`. These are the settle cycles, including the synchronizer latency.
- R4: With the default 2-stage synchronizer, any `pd_down_i` = 1 captured at an edge from E7 through E22 sets `invert_o` to 1. This is the 16-cycle vote window. `invert_o` shows the decision after edge E24.
- R5: If no down is captured in the vote window, `invert_o` is 0 after the decision. A down captured at E23 or later is not counted.
- R6: `boost_o` is 1 for exactly BOOST_TIME_PS / CLK_PERIOD_PS cycles, rounded up (60 cycles by default), starting after edge E24.
- R7: `locked_o` rises in the cycle after the boost interval ends (after edge E84 by default). From then on `boost_o` and `preset_o` are 0.
- R8: Once decided, `invert_o` does not change during the boost interval or while locked, whatever `pd_down_i` does.
- R9: If `ref_active_i` is sampled at 0 after the sequence has left the preset step, then in the next cycle `preset_o` is 1 and `invert_o`, `boost_o` and `locked_o` are 0.
- R10: At most one of `preset_o`, `boost_o` and `locked_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_active_i | input | 1 | Reference clock present |
| pd_down_i | input | 1 | Raw phase-detector output, 1 = down (less delay) |
| preset_o | output | 1 | Force delay control to preset value |
| invert_o | output | 1 | Select the 180 degree shifted clock phase |
| boost_o | output | 1 | Charge pump high-current enable |
| locked_o | output | 1 | Acquisition complete |

## Verification
The bench places single down pulses on both edges of the vote window: E6 and E23 just outside it, E7 and E22 just inside. A window shifted by one cycle, or a synchronizer of the wrong depth, shows up as a missed or spurious inversion. It counts the boost cycles one by one and notes the edge where lock arrives, so an off-by-one in the cycle conversion or the timer reload fails. It also toggles the detector during boost and lock to catch a phase select that keeps voting. It removes the reference clock during boost and during lock, to catch a controller that fails to restart or keeps a stale phase choice.

// File: rtl/dll_acq_pkg.sv
package dll_acq_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_PRESET  = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_OBSERVE = 3'd3,
        ST_BOOST   = 3'd4,
        ST_TRACK   = 3'd5
    } acq_state_e;

    typedef struct packed {
        logic preset;
        logic invert;
        logic boost;
        logic locked;
    } acq_ctrl_t;

    // Round a duration up to whole clock cycles.
    function automatic int cycles_for(input int dur_ps, input int period_ps);
        return (dur_ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dll_acq_sync.sv
module dll_acq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dll_acq_timer.sv
module dll_acq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] value_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load_i)       cnt_q <= value_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dll_acq_fsm.sv
module dll_acq_fsm
    import dll_acq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int VOTE_CYCLES   = 16,
    parameter int BOOST_CYCLES  = 60,
    parameter int CW            = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_active_i,
    input  logic          pd_down_i,
    input  logic          tmr_done_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_value_o,
    output acq_ctrl_t     ctrl_o
);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] VOTE_LOAD   = CW'(VOTE_CYCLES - 1);
    localparam logic [CW-1:0] BOOST_LOAD  = CW'(BOOST_CYCLES - 1);

    acq_state_e state_q, state_d;
    logic       seen_q, seen_d;
    logic       invert_q, invert_d;
    logic       running;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RESET;
            seen_q   <= 1'b0;
            invert_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            seen_q   <= seen_d;
            invert_q <= invert_d;
        end
    end

    assign running = (state_q == ST_SETTLE) || (state_q == ST_OBSERVE) ||
                     (state_q == ST_BOOST)  || (state_q == ST_TRACK);

    always_comb begin
        state_d     = state_q;
        seen_d      = seen_q;
        invert_d    = invert_q;
        tmr_load_o  = 1'b0;
        tmr_value_o = '0;
        unique case (state_q)
            ST_RESET: begin
                state_d  = ST_PRESET;
                seen_d   = 1'b0;
                invert_d = 1'b0;
            end
            ST_PRESET: begin
                seen_d   = 1'b0;
                invert_d = 1'b0;
                if (ref_active_i) begin
                    state_d     = ST_SETTLE;
                    tmr_load_o  = 1'b1;
                    tmr_value_o = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (tmr_done_i) begin
                    state_d     = ST_OBSERVE;
                    tmr_load_o  = 1'b1;
                    tmr_value_o = VOTE_LOAD;
                end
            end
            ST_OBSERVE: begin
                seen_d = seen_q | pd_down_i;
                if (tmr_done_i) begin
                    state_d     = ST_BOOST;
                    invert_d    = seen_q | pd_down_i;
                    tmr_load_o  = 1'b1;
                    tmr_value_o = BOOST_LOAD;
                end
            end
            ST_BOOST: begin
                if (tmr_done_i) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                state_d = ST_TRACK;
            end
            default: state_d = ST_RESET;
        endcase
        if (running && !ref_active_i) begin
            state_d    = ST_PRESET;
            seen_d     = 1'b0;
            invert_d   = 1'b0;
            tmr_load_o = 1'b0;
        end
    end

    always_comb begin
        ctrl_o.preset = (state_q == ST_RESET) || (state_q == ST_PRESET);
        ctrl_o.invert = invert_q;
        ctrl_o.boost  = (state_q == ST_BOOST);
        ctrl_o.locked = (state_q == ST_TRACK);
    end
endmodule

// File: rtl/dll_acq_ctrl.sv
module dll_acq_ctrl
    import dll_acq_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 8,
    parameter int VOTE_CYCLES   = 16,
    parameter int CLK_PERIOD_PS = 5000,
    parameter int BOOST_TIME_PS = 300000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_active_i,
    input  logic pd_down_i,
    output logic preset_o,
    output logic invert_o,
    output logic boost_o,
    output logic locked_o
);
    localparam int BOOST_CYCLES = cycles_for(BOOST_TIME_PS, CLK_PERIOD_PS);
    localparam int MAX_COUNT    = max3(SETTLE_CYCLES, VOTE_CYCLES, BOOST_CYCLES);
    localparam int CW           = $clog2(MAX_COUNT) + 1;

    logic          pd_sync;
    logic          tmr_load;
    logic [CW-1:0] tmr_value;
    logic          tmr_done;
    acq_ctrl_t     ctrl;

    dll_acq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pd_down_i),
        .q_o (pd_sync)
    );

    dll_acq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .value_i (tmr_value),
        .done_o  (tmr_done)
    );

    dll_acq_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .VOTE_CYCLES   (VOTE_CYCLES),
        .BOOST_CYCLES  (BOOST_CYCLES),
        .CW            (CW)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ref_active_i (ref_active_i),
        .pd_down_i    (pd_sync),
        .tmr_done_i   (tmr_done),
        .tmr_load_o   (tmr_load),
        .tmr_value_o  (tmr_value),
        .ctrl_o       (ctrl)
    );

    assign preset_o = ctrl.preset;
    assign invert_o = ctrl.invert;
    assign boost_o  = ctrl.boost;
    assign locked_o = ctrl.locked;
endmodule

// File: rtl/dll_acq_ctrl_chk.sv
module dll_acq_ctrl_chk #(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int BOOST_TIME_PS = 300000
) (
    input logic clk,
    input logic rst,
    input logic ref_active_i,
    input logic preset_o,
    input logic invert_o,
    input logic boost_o,
    input logic locked_o
);
    localparam int BOOST_CYCLES = dll_acq_pkg::cycles_for(BOOST_TIME_PS, CLK_PERIOD_PS);

    logic [31:0] boost_run_q;

    always_ff @(posedge clk) begin
        if (rst)          boost_run_q <= '0;
        else if (boost_o) boost_run_q <= boost_run_q + 1;
        else              boost_run_q <= '0;
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (preset_o && !invert_o && !boost_o && !locked_o));

    // R10
    a_r10_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot0({preset_o, boost_o, locked_o}));

    // R9
    a_r9_loss_restart: assert property (@(posedge clk) disable iff (rst)
        (!ref_active_i && !preset_o) |=> (preset_o && !invert_o && !boost_o && !locked_o));

    // R6
    a_r6_boost_bound: assert property (@(posedge clk) disable iff (rst)
        boost_o |-> (boost_run_q < BOOST_CYCLES));

    // R6
    a_r6_boost_full: assert property (@(posedge clk) disable iff (rst)
        ($fell(boost_o) && locked_o) |-> (boost_run_q == BOOST_CYCLES));

    // R8
    a_r8_invert_hold: assert property (@(posedge clk) disable iff (rst)
        (boost_o || locked_o) |=> (preset_o || $stable(invert_o)));

    // R7
    a_r7_lock_after_boost: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(boost_o));
endmodule

bind dll_acq_ctrl dll_acq_ctrl_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .BOOST_TIME_PS (BOOST_TIME_PS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ref_active_i (ref_active_i),
    .preset_o     (preset_o),
    .invert_o     (invert_o),
    .boost_o      (boost_o),
    .locked_o     (locked_o)
);

// File: tb/dll_acq_ctrl_tb.sv
module dll_acq_ctrl_tb;
    localparam int BOOST_N   = 60;   // 300000 ps / 5000 ps
    localparam int DECIDE_K  = 24;   // 8 settle + 16 vote
    localparam int LOCK_K    = DECIDE_K + BOOST_N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_active = 1'b0;
    logic pd_down = 1'b0;
    logic preset_o, invert_o, boost_o, locked_o;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    dll_acq_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .ref_active_i (ref_active),
        .pd_down_i    (pd_down),
        .preset_o     (preset_o),
        .invert_o     (invert_o),
        .boost_o      (boost_o),
        .locked_o     (locked_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one acquisition. pd_down is 1 at edge E_k for lo<=k<=hi,
    // and toggles from toggle_from on (if >=0). Stops after edge E_(last).
    task automatic run_acq(input int lo, input int hi, input int toggle_from,
                           input int last, input int exp_inv, input string tag);
        int boost_cnt = 0;
        int first_boost = -1;
        int first_lock = -1;
        int inv_changes = 0;
        int inv_prev = -1;
        ref_active = 1'b1;
        for (int k = 0; k <= last; k++) begin
            pd_down = ((k >= lo) && (k <= hi)) ||
                      ((toggle_from >= 0) && (k >= toggle_from) && (k % 2 == 0));
            @(posedge clk);
            @(negedge clk);
            if (k == 0) check({tag, " R2 preset falls"}, preset_o, 0);
            if (boost_o) begin
                boost_cnt++;
                if (first_boost < 0) first_boost = k;
            end
            if (locked_o && first_lock < 0) begin
                first_lock = k;
                check({tag, " R7 boost off at lock"}, boost_o, 0);
            end
            if (k >= DECIDE_K) begin
                if (inv_prev >= 0 && inv_prev != int'(invert_o)) inv_changes++;
                inv_prev = int'(invert_o);
            end
        end
        pd_down = 1'b0;
        check({tag, " R4/R5 invert decision"}, inv_prev, exp_inv);
        if (last >= LOCK_K) begin
            check({tag, " R6 boost start"}, first_boost, DECIDE_K);
            check({tag, " R6 boost length"}, boost_cnt, BOOST_N);
            check({tag, " R7 lock edge"}, first_lock, LOCK_K);
            check({tag, " R8 invert stable"}, inv_changes, 0);
        end
    endtask

    task automatic drop_ref(input string tag);
        ref_active = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R9 preset"}, preset_o, 1);
        check({tag, " R9 invert"}, invert_o, 0);
        check({tag, " R9 boost"}, boost_o, 0);
        check({tag, " R9 locked"}, locked_o, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 preset in reset", preset_o, 1);
        check("R1 invert in reset", invert_o, 0);
        check("R1 boost in reset", boost_o, 0);
        check("R1 locked in reset", locked_o, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 preset after reset", preset_o, 1);
        check("R1 locked after reset", locked_o, 0);
    endtask

    task automatic t_preset_hold();
        int bad = 0;
        for (int i = 0; i < 12; i++) begin
            pd_down = i[0];
            @(posedge clk);
            @(negedge clk);
            if (!preset_o || boost_o || locked_o || invert_o) bad++;
        end
        pd_down = 1'b0;
        check("R2 preset held without reference", bad, 0);
    endtask

    task automatic t_clean_lock();
        run_acq(1, 0, -1, LOCK_K + 5, 0, "clean");
        drop_ref("after clean lock");
    endtask

    task automatic t_ignore_window();
        run_acq(0, 6, -1, LOCK_K + 2, 0, "R3 settle downs");
        drop_ref("after settle test");
    endtask

    task automatic t_window_edges();
        run_acq(7, 7, -1, DECIDE_K + 2, 1, "R4 first vote edge");
        drop_ref("R4 first edge");
        run_acq(22, 22, -1, DECIDE_K + 2, 1, "R4 last vote edge");
        drop_ref("R4 last edge");
        run_acq(23, 40, -1, LOCK_K + 2, 0, "R5 late downs");
        drop_ref("R5 late");
    endtask

    task automatic t_invert_stable();
        run_acq(15, 15, DECIDE_K, LOCK_K + 10, 1, "R8 toggling detector");
        drop_ref("R9 from lock");
    endtask

    task automatic t_loss_in_boost();
        run_acq(10, 12, -1, DECIDE_K + 20, 1, "R9 pre-loss");
        check("R9 in boost before loss", boost_o, 1);
        drop_ref("R9 from boost");
        run_acq(1, 0, -1, LOCK_K + 1, 0, "R9 reacquire");
        check("R9 locked again", locked_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_preset_hold();
        t_clean_lock();
        t_ignore_window();
        t_window_edges();
        t_invert_stable();
        t_loss_in_boost();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule